// File: doc/BRIEF.md
# Banked Two-Slot Debug Trace Multiplexer

This block lets an external logic analyzer watch internal nets of a chip through a small number of pins. Four banks of probe signals, each 48 bits wide, arrive on one flat input bus. A 2-bit select input, driven at run time by a separate control path, chooses which bank is visible. The block never needs rebuilding to look at a different bank.

The chosen 48-bit word is registered once per frame. A frame is two clock cycles, called slots. In the first slot the 24 data pins carry the low half of the word. In the second slot they carry the high half. A forwarded capture clock pin is low in the first slot and high in the second, so its level tells the analyzer which half is on the pins. Everything runs in one clock domain.

A two-state machine sequences the slots. In `SLOT_LO` the low half is on the pins. In `SLOT_HI` the high half is on the pins.
- Transition `SLOT_LO -> SLOT_HI` happens on every clock edge out of reset.
- Transition `SLOT_HI -> SLOT_LO` also happens on every clock edge. This is the frame-start edge: the bank select and the selected bank word are both sampled here.
- Reset forces `SLOT_LO`.

Top module: `trace_mux`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge selects bank 0 and forces slot 0. After it, `pin_clk` is 0 and `pin_data` shows bits [23:0] of bank 0 as sampled at that edge. The value of `bank_sel` has no effect during reset.
- R2: Bank k occupies `probe_bus[48*k+47 : 48*k]`. Select value k (0 to 3) chooses bank k.
- R3: In slot 0 (`pin_clk` = 0), `pin_data` equals bits [23:0] of the word captured at the start of the current frame.
- R4: In slot 1 (`pin_clk` = 1), `pin_data` equals bits [47:24] of the same captured word that was shown in the preceding slot 0.
- R5: Out of reset, `pin_clk` changes level on every clock edge. The first cycle after reset is released is slot 1.
- R6: The bank word is sampled only at the frame-start edge, which is the edge that enters slot 0. A probe change made in any other cycle does not reach the pins before the next frame.
- R7: `bank_sel` is sampled only at the frame-start edge. A change of select inside a frame has no effect on that frame, so no frame mixes two banks.
- R8: Any bank can be chosen at run time. Each frame shows the bank named by `bank_sel` at its own frame-start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock. One slot is one cycle. |
| rst | input | 1 | Synchronous reset, active high. |
| bank_sel | input | 2 | Run-time bank choice. |
| probe_bus | input | 192 | Four 48-bit probe banks, bank 0 in the lowest bits. |
| pin_data | output | 24 | Time-sliced data pins. |
| pin_clk | output | 1 | Forwarded capture clock. Its level equals the current slot. |

## Verification
A slot state that is stuck or out of step shows at the ports on the very next edge. Either `pin_clk` fails to toggle, or a half appears in the wrong slot, so the fault is visible within one cycle.

A wrong capture timing, where the word or the select is taken in a slot other than the frame-start slot, shows within one frame. It appears as a high half that does not belong with the preceding low half, or as a bank that differs from the one selected at the frame start. The bench changes the select and the probe values every cycle so that such faults have a chance to surface, and it walks a single set bit through every position of every bank so that a misrouted bit also shows up.

// File: rtl/trace_mux_pkg.sv
package trace_mux_pkg;

    // Which half of the frame is currently on the pins.
    typedef enum logic {
        SLOT_LO = 1'b0,
        SLOT_HI = 1'b1
    } slot_e;

endpackage

// File: rtl/trace_slot_fsm.sv
module trace_slot_fsm
    import trace_mux_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot,
    output logic  frame_start
);

    slot_e state_q;
    slot_e state_d;

    // Next-state logic: the two slots simply alternate.
    always_comb begin
        unique case (state_q)
            SLOT_LO: state_d = SLOT_HI;
            SLOT_HI: state_d = SLOT_LO;
            default: state_d = SLOT_LO;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_LO;
        else     state_q <= state_d;
    end

    // Output logic: the edge leaving SLOT_HI (or any reset edge) starts a frame.
    always_comb begin
        slot = state_q;
        unique case (state_q)
            SLOT_LO: frame_start = rst;
            SLOT_HI: frame_start = 1'b1;
            default: frame_start = 1'b1;
        endcase
    end

    // R5
    slot_alt_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> state_q != $past(state_q));

    // R6
    frame_start_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

// File: rtl/trace_bank_mux.sv
module trace_bank_mux #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 48,
    localparam int SEL_W    = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS*BANK_W-1:0] probe_bus,
    input  logic [SEL_W-1:0]            sel,
    output logic [BANK_W-1:0]           word
);

    logic [BANK_W-1:0] bank_arr [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_arr[g] = probe_bus[g*BANK_W +: BANK_W];
    end

    always_comb word = bank_arr[sel];

endmodule

// File: rtl/trace_frame_reg.sv
module trace_frame_reg #(
    parameter int BANK_W    = 48,
    parameter int SEL_W     = 2,
    localparam int PIN_W    = BANK_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [BANK_W-1:0] word_in,
    output logic [PIN_W-1:0]  pin_data,
    output logic              pin_clk
);

    logic [BANK_W-1:0] word_q;
    logic [PIN_W-1:0]  pin_q;
    logic              clk_q;
    logic [SEL_W-1:0]  sel_q;

    // Capture at frame start, then present the upper half in the second slot.
    always_ff @(posedge clk) begin
        if (frame_start) begin
            word_q <= word_in;
            sel_q  <= sel_in;
            pin_q  <= word_in[PIN_W-1:0];
            clk_q  <= 1'b0;
        end else begin
            pin_q  <= word_q[BANK_W-1:PIN_W];
            clk_q  <= 1'b1;
        end
    end

    assign pin_data = pin_q;
    assign pin_clk  = clk_q;

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clk_q |-> $stable(sel_q));

    // R3
    lo_half_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_q |-> pin_q == word_q[PIN_W-1:0]);

    // R4
    hi_half_chk: assert property (@(posedge clk) disable iff (rst)
        clk_q |-> pin_q == word_q[BANK_W-1:PIN_W]);

    // R5
    clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> clk_q != $past(clk_q));

endmodule

// File: rtl/trace_mux.sv
module trace_mux
    import trace_mux_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 48,
    localparam int SEL_W    = $clog2(NUM_BANKS),
    localparam int PIN_W    = BANK_W / 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SEL_W-1:0]            bank_sel,
    input  logic [NUM_BANKS*BANK_W-1:0] probe_bus,
    output logic [PIN_W-1:0]            pin_data,
    output logic                        pin_clk
);

    slot_e             slot;
    logic              frame_start;
    logic [SEL_W-1:0]  sel_eff;
    logic [BANK_W-1:0] word;

    // Reset forces bank 0 regardless of the select input.
    assign sel_eff = rst ? '0 : bank_sel;

    trace_slot_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .slot        (slot),
        .frame_start (frame_start)
    );

    trace_bank_mux #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_mux (
        .probe_bus (probe_bus),
        .sel       (sel_eff),
        .word      (word)
    );

    trace_frame_reg #(
        .BANK_W (BANK_W),
        .SEL_W  (SEL_W)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .sel_in      (sel_eff),
        .word_in     (word),
        .pin_data    (pin_data),
        .pin_clk     (pin_clk)
    );

    // R5
    slot_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_HI) |-> pin_clk);

endmodule

// File: tb/sim_trace_mux.sv
module sim_trace_mux;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   bank_sel = 2'd3;
    logic [191:0] probe_bus = '0;
    logic [23:0]  pin_data;
    logic         pin_clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    trace_mux u0 (
        .clk       (clk),
        .rst       (rst),
        .bank_sel  (bank_sel),
        .probe_bus (probe_bus),
        .pin_data  (pin_data),
        .pin_clk   (pin_clk)
    );

    // Reference built from the requirements.
    logic [47:0] m_word;
    logic [23:0] m_pin;
    logic        m_clk;
    always @(posedge clk) begin
        if (rst) begin
            m_word <= probe_bus[47:0];
            m_pin  <= probe_bus[23:0];
            m_clk  <= 1'b0;
        end else if (!m_clk) begin
            m_pin  <= m_word[47:24];
            m_clk  <= 1'b1;
        end else begin
            m_word <= probe_bus[48*bank_sel +: 48];
            m_pin  <= probe_bus[48*bank_sel +: 24];
            m_clk  <= 1'b0;
        end
    end

    function automatic logic [31:0] xs32(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic rand_probe();
        for (int k = 0; k < 6; k++) begin
            seed = xs32(seed);
            probe_bus[k*32 +: 32] = seed;
        end
    endtask

    task automatic check(input string tag);
        string half;
        half = m_clk ? "R4" : "R3";
        checks++;
        if (pin_data !== m_pin) begin
            failures++;
            $display("FAIL %s %s pin_data actual=%h expected=%h", tag, half, pin_data, m_pin);
        end
        checks++;
        if (pin_clk !== m_clk) begin
            failures++;
            $display("FAIL %s R5 pin_clk actual=%b expected=%b", tag, pin_clk, m_clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset with a non-zero select, bank 0 changing.
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 reset");
            rand_probe();
            bank_sel = 2'(i + 1);
        end
        rst = 1'b0;
        // R2/R8: hold each select for several frames.
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                check("R2/R8 sweep");
                bank_sel = 2'(b);
                rand_probe();
            end
        end
        // R6/R7: select and probes change every cycle.
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            check("R6/R7 churn");
            seed = xs32(seed);
            bank_sel = seed[9:8];
            rand_probe();
        end
        // R1: reset in mid-run, then recover.
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 midreset");
            rand_probe();
        end
        rst = 1'b0;
        // R2: walking one through every bit of every bank.
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 48; i++) begin
                for (int s = 0; s < 2; s++) begin
                    @(negedge clk);
                    check("R2 walk");
                    bank_sel = 2'(b);
                    probe_bus = '0;
                    probe_bus[48*b + i] = 1'b1;
                end
            end
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 walk tail");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule